// File: doc/BRIEF.md
# Extended Vectored Interrupt Router

This block collects a wide set of interrupt vector inputs for one routing node and holds each event as a pending bit until software clears it. Each vector has an enable bit and a route byte. The route byte names a set of target cores in a group of four and the node that should service the vector. Vectors are handled in groups of 32. Each group has a one-byte line map that picks which interrupt line it drives on a core.

Software reaches all of the state through a 32-bit register port. Every register honours per-byte write enables. Status registers are write-one-to-clear. The output is one small vector of interrupt lines per core. Line l of core c is asserted while at least one vector is pending and enabled, lists core c in its route bitmap, carries the local node number, and belongs to a group whose line map selects line l.

Top module: `xvr_router`

## Requirements
- R1: After reset every enable bit reads as one. Bounce, route, line-map and status registers read as zero, and every interrupt line is low.
- R2: With edge triggering (LEVEL_TRIG=0), a low-to-high change on a vector input sets its pending bit on the next clock edge. An input that stays high does not set the bit again after it has been cleared.
- R3: The status word at byte address 0x1800 + 4*(v>>5) shows the pending bit of vector v at bit v&31. Two consecutive words therefore form the 64-bit word v/64, holding vector v at bit v%64.
- R4: A write to a status word clears exactly the bits written as one within the enabled bytes. All other pending bits are left unchanged.
- R5: When a pending set and a write-one clear reach the same bit in the same cycle, the bit ends up set.
- R6: The enable bit of vector v is bit v&31 of the word at 0x1600 + 4*(v>>5). A disabled vector still latches as pending but drives no line. Enabling it again drives its line.
- R7: The route byte of vector v is byte v&3 of the word at 0x1C00 + 4*(v>>2). In that byte, bits [3:0] are the core bitmap and bits [7:4] are the node number. A vector drives core c only if bitmap bit c is set and the node field equals node_id.
- R8: Writes to any register update only the bytes whose reg_be bit is set. The other bytes of the word keep their values.
- R9: The line-map byte of group g=v>>5 is byte g&3 of the word at 0x14C0 + 4*(g>>2). Bit l of that byte drives irq_o[c*LINES+l]. A zero line map leaves the vector pending but drives no line.
- R10: The bounce bit of vector v is bit v&31 of the word at 0x1680 + 4*(v>>5). It can be written and read back, and it has no effect on irq_o.
- R11: Reading an unmapped address returns zero, and writing one changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| node_id | input | 4 | Number of this routing node |
| vec_in | input | NUM_VEC | Interrupt vector inputs |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register byte address, word aligned |
| reg_wdata | input | 32 | Register write data |
| reg_be | input | 4 | Byte enables for the write |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_o | output | CORES*LINES | Interrupt lines; core c line l at index c*LINES+l |

## Verification
The bench builds the router with 64 vectors, four cores, four lines per core and edge triggering. With that size, all 64 vectors can be swept one at a time through pulse, status readback, line check and clear, with every route word and both line-map groups set up. The smaller configuration also puts the byte-lane corners within a few writes: node mismatch, route byte masking, zero line maps, disabled vectors and set-versus-clear collisions.

// File: rtl/xvr_pkg.sv
package xvr_pkg;
   localparam logic [15:0] OFF_LMAP  = 16'h14C0;
   localparam logic [15:0] OFF_EN    = 16'h1600;
   localparam logic [15:0] OFF_BNC   = 16'h1680;
   localparam logic [15:0] OFF_STAT  = 16'h1800;
   localparam logic [15:0] OFF_ROUTE = 16'h1C00;

   function automatic logic [31:0] lane_mask(input logic [3:0] be);
      return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
   endfunction

   function automatic int lmap_bytes(input int nvec);
      return ((nvec / 32 + 3) / 4) * 4;
   endfunction

   function automatic logic [15:0] waddr(input logic [15:0] base, input int idx);
      return base + 16'(4 * idx);
   endfunction
endpackage

// File: rtl/xvr_pending.sv
module xvr_pending #(
   parameter int NUM_VEC    = 256,
   parameter bit LEVEL_TRIG = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_VEC-1:0] vec_in,
   input  logic [NUM_VEC-1:0] clr_i,
   output logic [NUM_VEC-1:0] pend_o
);
   logic [NUM_VEC-1:0] set_w;

   generate
      if (LEVEL_TRIG) begin : g_level
         assign set_w = vec_in;
      end else begin : g_edge
         logic [NUM_VEC-1:0] prev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= '0;
            else        prev_q <= vec_in;
         end
         assign set_w = vec_in & ~prev_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_o <= '0;
      else        pend_o <= (pend_o & ~clr_i) | set_w;
   end

   // Set requests always land, even when a clear hits the same bit.
   p_set_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend_o & $past(set_w)) == $past(set_w)));
   // A clear with no simultaneous set empties the bit.
   p_clear_takes_r4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend_o & $past(clr_i & ~set_w)) == '0));
   // A bit rises only when a set request was present.
   p_no_spurious_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend_o & ~$past(pend_o) & ~$past(set_w)) == '0));
endmodule

// File: rtl/xvr_cfg.sv
module xvr_cfg
   import xvr_pkg::*;
#(
   parameter int NUM_VEC = 256
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_i,
   input  logic [15:0]                  addr_i,
   input  logic [31:0]                  wdata_i,
   input  logic [3:0]                   be_i,
   output logic [NUM_VEC-1:0]           en_o,
   output logic [NUM_VEC-1:0]           bnc_o,
   output logic [NUM_VEC-1:0][7:0]      route_o,
   output logic [lmap_bytes(NUM_VEC)-1:0][7:0] lmap_o,
   output logic [31:0]                  rdata_o
);
   localparam int VW = NUM_VEC / 32;
   localparam int RW = NUM_VEC / 4;
   localparam int LB = lmap_bytes(NUM_VEC);
   localparam int LW = LB / 4;

   logic [31:0] bmask;
   assign bmask = lane_mask(be_i);

   generate
      for (genvar w = 0; w < VW; w++) begin : g_vw
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               en_o[w*32 +: 32]  <= '1;
               bnc_o[w*32 +: 32] <= '0;
            end else if (wr_i) begin
               if (addr_i == waddr(OFF_EN, w))
                  en_o[w*32 +: 32] <= (en_o[w*32 +: 32] & ~bmask) | (wdata_i & bmask);
               if (addr_i == waddr(OFF_BNC, w))
                  bnc_o[w*32 +: 32] <= (bnc_o[w*32 +: 32] & ~bmask) | (wdata_i & bmask);
            end
         end
      end

      for (genvar w = 0; w < RW; w++) begin : g_rw
         for (genvar b = 0; b < 4; b++) begin : g_byte
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) route_o[w*4+b] <= '0;
               else if (wr_i && be_i[b] && addr_i == waddr(OFF_ROUTE, w))
                  route_o[w*4+b] <= wdata_i[b*8 +: 8];
            end
            p_route_bytemask_r8: assert property (@(posedge clk) disable iff (!rst_n)
               (wr_i && !be_i[b] && addr_i == waddr(OFF_ROUTE, w)) |=> $stable(route_o[w*4+b]));
         end
      end

      for (genvar w = 0; w < LW; w++) begin : g_lw
         for (genvar b = 0; b < 4; b++) begin : g_byte
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) lmap_o[w*4+b] <= '0;
               else if (wr_i && be_i[b] && addr_i == waddr(OFF_LMAP, w))
                  lmap_o[w*4+b] <= wdata_i[b*8 +: 8];
            end
         end
      end
   endgenerate

   always_comb begin
      rdata_o = '0;
      for (int w = 0; w < VW; w++) begin
         if (addr_i == waddr(OFF_EN, w))  rdata_o = en_o[w*32 +: 32];
         if (addr_i == waddr(OFF_BNC, w)) rdata_o = bnc_o[w*32 +: 32];
      end
      for (int w = 0; w < RW; w++)
         if (addr_i == waddr(OFF_ROUTE, w)) rdata_o = route_o[w*4 +: 4];
      for (int w = 0; w < LW; w++)
         if (addr_i == waddr(OFF_LMAP, w)) rdata_o = lmap_o[w*4 +: 4];
   end
endmodule

// File: rtl/xvr_steer.sv
module xvr_steer
   import xvr_pkg::*;
#(
   parameter int NUM_VEC = 256,
   parameter int CORES   = 4,
   parameter int LINES   = 8
) (
   input  logic [NUM_VEC-1:0]              pend_i,
   input  logic [NUM_VEC-1:0]              en_i,
   input  logic [NUM_VEC-1:0][7:0]         route_i,
   input  logic [lmap_bytes(NUM_VEC)-1:0][7:0] lmap_i,
   input  logic [3:0]                      node_i,
   output logic [CORES*LINES-1:0]          irq_o
);
   logic [NUM_VEC-1:0] live;

   always_comb begin
      for (int v = 0; v < NUM_VEC; v++)
         live[v] = pend_i[v] & en_i[v] & (route_i[v][7:4] == node_i);
   end

   always_comb begin
      irq_o = '0;
      for (int v = 0; v < NUM_VEC; v++) begin
         for (int c = 0; c < CORES; c++) begin
            for (int l = 0; l < LINES; l++) begin
               if (live[v] && route_i[v][c] && lmap_i[v/32][l])
                  irq_o[c*LINES+l] = 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/xvr_router.sv
module xvr_router
   import xvr_pkg::*;
#(
   parameter int NUM_VEC    = 256,
   parameter int CORES      = 4,
   parameter int LINES      = 8,
   parameter bit LEVEL_TRIG = 1'b0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [3:0]             node_id,
   input  logic [NUM_VEC-1:0]     vec_in,
   input  logic                   reg_wr,
   input  logic [15:0]            reg_addr,
   input  logic [31:0]            reg_wdata,
   input  logic [3:0]             reg_be,
   output logic [31:0]            reg_rdata,
   output logic [CORES*LINES-1:0] irq_o
);
   localparam int VW = NUM_VEC / 32;
   localparam int LB = lmap_bytes(NUM_VEC);

   generate
      if (NUM_VEC % 32 != 0 || NUM_VEC < 32 || NUM_VEC > 256) begin : g_bad_vec
         $error("xvr_router: NUM_VEC must be a multiple of 32 in 32..256");
      end
      if (CORES < 1 || CORES > 4) begin : g_bad_cores
         $error("xvr_router: CORES must be 1..4");
      end
      if (LINES < 1 || LINES > 8) begin : g_bad_lines
         $error("xvr_router: LINES must be 1..8");
      end
   endgenerate

   logic [NUM_VEC-1:0]      pend, en, bnc, clr;
   logic [NUM_VEC-1:0][7:0] route;
   logic [LB-1:0][7:0]      lmap;
   logic [31:0]             cfg_rdata, stat_rdata, bmask;

   assign bmask = lane_mask(reg_be);

   always_comb begin
      clr        = '0;
      stat_rdata = '0;
      for (int w = 0; w < VW; w++) begin
         if (reg_addr == waddr(OFF_STAT, w)) begin
            stat_rdata = pend[w*32 +: 32];
            if (reg_wr) clr[w*32 +: 32] = reg_wdata & bmask;
         end
      end
   end

   assign reg_rdata = cfg_rdata | stat_rdata;

   xvr_pending #(.NUM_VEC(NUM_VEC), .LEVEL_TRIG(LEVEL_TRIG)) u_pend (
      .clk(clk), .rst_n(rst_n), .vec_in(vec_in), .clr_i(clr), .pend_o(pend));

   xvr_cfg #(.NUM_VEC(NUM_VEC)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .addr_i(reg_addr),
      .wdata_i(reg_wdata), .be_i(reg_be), .en_o(en), .bnc_o(bnc),
      .route_o(route), .lmap_o(lmap), .rdata_o(cfg_rdata));

   xvr_steer #(.NUM_VEC(NUM_VEC), .CORES(CORES), .LINES(LINES)) u_steer (
      .pend_i(pend), .en_i(en), .route_i(route), .lmap_i(lmap),
      .node_i(node_id), .irq_o(irq_o));

   // A raised line needs at least one pending, enabled vector.
   p_line_needs_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_o) |-> (|(pend & en)));
   // Bounce bits never matter to the lines: a bounce-only change keeps irq stable.
   p_bounce_inert_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(pend) && $stable(en) && $stable(route) && $stable(lmap)
       && $stable(node_id) && !$stable(bnc)) |-> $stable(irq_o));
endmodule

// File: tb/xvr_router_test.sv
`timescale 1ns/1ps
module xvr_router_test;
   localparam int NV = 64, NC = 4, NL = 4;
   localparam logic [3:0] NODE = 4'h5;

   logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
   logic [NV-1:0] vec_in = '0;
   logic [15:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic [3:0] reg_be = '0;
   logic [NC*NL-1:0] irq_o;
   int n_chk = 0, n_bad = 0;

   always #2.5 clk = ~clk;

   xvr_router #(.NUM_VEC(NV), .CORES(NC), .LINES(NL), .LEVEL_TRIG(1'b0)) uut (
      .clk(clk), .rst_n(rst_n), .node_id(NODE), .vec_in(vec_in),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_be(reg_be), .reg_rdata(reg_rdata), .irq_o(irq_o));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [31:0] d, input logic [3:0] be);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_be = be;
      @(negedge clk);
      reg_wr = 1'b0; reg_be = '0;
   endtask

   task automatic rd(input logic [15:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic pulse(input int v);
      @(negedge clk); vec_in[v] = 1'b1;
      @(negedge clk); vec_in[v] = 1'b0;
   endtask

   // Group 0 uses line 1, group 1 uses line 3 in the sweep setup.
   function automatic int line_of(input int v);
      return (v < 32) ? 1 : 3;
   endfunction

   function automatic logic [31:0] irq_bit(input int core, input int line);
      return 32'(1) << (core * NL + line);
   endfunction

   initial begin
      #(200000 * 5);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset values
      for (int w = 0; w < 2; w++) begin
         rd(16'h1600 + 16'(4*w), d); chk("R1 enable reset", d, 32'hFFFF_FFFF);
         rd(16'h1680 + 16'(4*w), d); chk("R1 bounce reset", d, 32'h0);
         rd(16'h1800 + 16'(4*w), d); chk("R1 status reset", d, 32'h0);
      end
      rd(16'h1C00, d); chk("R1 route reset", d, 32'h0);
      rd(16'h14C0, d); chk("R1 linemap reset", d, 32'h0);
      chk("R1 irq reset", 32'(irq_o), 32'h0);

      // R11 unmapped address
      wr(16'h1700, 32'hDEAD_BEEF, 4'hF);
      rd(16'h1700, d); chk("R11 unmapped read", d, 32'h0);
      rd(16'h1600, d); chk("R11 write leaked", d, 32'hFFFF_FFFF);

      // Setup: each vector to core v%4 at the local node.
      for (int w = 0; w < 16; w++) wr(16'h1C00 + 16'(4*w), 32'h5854_5251, 4'hF);
      wr(16'h14C0, 32'h0000_0802, 4'hF);
      rd(16'h14C0, d); chk("R9 linemap readback", d, 32'h0000_0802);

      // Full sweep: R2 R3 R7 R9 R4
      for (int v = 0; v < NV; v++) begin
         pulse(v);
         rd(16'h1800 + 16'(4*(v/32)), d);
         chk($sformatf("R3 status v%0d", v), d, 32'(1) << (v % 32));
         chk($sformatf("R7 R9 irq v%0d", v), 32'(irq_o), irq_bit(v % 4, line_of(v)));
         wr(16'h1800 + 16'(4*(v/32)), 32'(1) << (v % 32), 4'hF);
         rd(16'h1800 + 16'(4*(v/32)), d);
         chk($sformatf("R4 cleared v%0d", v), d, 32'h0);
         chk($sformatf("R4 irq low v%0d", v), 32'(irq_o), 32'h0);
      end

      // R7 node mismatch, R8 byte mask on route
      wr(16'h1C00, 32'h6100_0000, 4'b1000);
      rd(16'h1C00, d); chk("R8 route byte mask", d, 32'h6154_5251);
      pulse(3);
      rd(16'h1800, d); chk("R7 foreign node pending", d, 32'h8);
      chk("R7 foreign node no irq", 32'(irq_o), 32'h0);
      wr(16'h1C00, 32'h5100_0000, 4'b1000);
      #1 chk("R7 local node irq", 32'(irq_o), irq_bit(0, 1));
      wr(16'h1800, 32'h8, 4'hF);

      // R6 enable
      wr(16'h1600, ~(32'h1 << 5), 4'hF);
      pulse(5);
      rd(16'h1800, d); chk("R6 disabled pending", d, 32'h20);
      chk("R6 disabled no irq", 32'(irq_o), 32'h0);
      wr(16'h1600, 32'hFFFF_FFFF, 4'hF);
      #1 chk("R6 re-enabled irq", 32'(irq_o), irq_bit(1, 1));
      wr(16'h1800, 32'h20, 4'hF);

      // R9 zero linemap for group 1
      wr(16'h14C0, 32'h0, 4'b0010);
      pulse(40);
      rd(16'h1804, d); chk("R9 zero map pending", d, 32'h100);
      chk("R9 zero map no irq", 32'(irq_o), 32'h0);
      wr(16'h14C0, 32'h0000_0800, 4'b0010);
      #1 chk("R9 map restored irq", 32'(irq_o), irq_bit(0, 3));
      wr(16'h1804, 32'h100, 4'hF);

      // R5 set beats clear
      pulse(6);
      @(negedge clk);
      vec_in[7] = 1'b1;
      reg_wr = 1'b1; reg_addr = 16'h1800; reg_wdata = 32'hC0; reg_be = 4'hF;
      @(negedge clk);
      reg_wr = 1'b0; reg_be = '0;
      rd(16'h1800, d); chk("R5 set wins", d, 32'h80);
      // R2: input held high, clear, no re-set
      wr(16'h1800, 32'h80, 4'hF);
      repeat (3) @(negedge clk);
      rd(16'h1800, d); chk("R2 held high stays clear", d, 32'h0);
      vec_in[7] = 1'b0;

      // R4 byte enables on clear
      pulse(1); pulse(9);
      wr(16'h1800, 32'h202, 4'b0001);
      rd(16'h1800, d); chk("R4 byte-masked clear", d, 32'h200);
      wr(16'h1800, 32'h200, 4'hF);

      // R10 bounce inert
      pulse(33);
      wr(16'h1684, 32'hA5A5_A5A5, 4'hF);
      rd(16'h1684, d); chk("R10 bounce readback", d, 32'hA5A5_A5A5);
      chk("R10 bounce no effect", 32'(irq_o), irq_bit(1, 3));
      wr(16'h1804, 32'h2, 4'hF);
      chk("R10 irq after clear", 32'(irq_o), 32'h0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule